// File: doc/BRIEF.md
# Host Port Access Sequencer

This block lives on a host processor's memory bus and performs complete transfers through the 16-bit parallel host port of a remote signal processor. A command carries a remote start address, a word count, a direction, a flag that picks the fixed-location data register instead of the auto-incrementing one, and the half-word order. For every command the block first writes the remote control register, then loads the remote address register, and then moves the data words one at a time through the selected data register.

Each 32-bit word crosses the port as two 16-bit accesses on the low half of the host data bus. A half-select output marks which half is on the wire. The register select and the direction are encoded into host address bits, so the host bus decoder and the port pins need no extra glue. Outbound words come in on a valid/ready stream, and inbound words leave on another valid/ready stream. Each access waits while the remote busy line is high. If the remote side never answers, a programmable timeout ends the command with an error flag.

Top module: `hport_seq`

## Requirements
- R1: After reset, cmd_ready is 1, and bus_cs, done, err, rd_valid and wr_ready are all 0.
- R2: An accepted command produces, in this order, two accesses to the control register (select 00), two accesses to the address register (select 01), and then two accesses per data word.
- R3: The control register value is zero except bit 0, which equals cmd_low_first.
- R4: bus_addr is 0x8000_0000 with bit 4 set for a write to the remote side and clear for a read, and bits 3:2 carry the register select. Control and address accesses are always writes, and the address register receives cmd_addr.
- R5: Data accesses use select 10 (auto-increment) when cmd_fixed is 0 and select 11 (fixed location) when cmd_fixed is 1.
- R6: bus_hsel is 0 for the low half (bits 15:0) and 1 for the high half (bits 31:16). The low half goes first when cmd_low_first is 1, and the high half goes first otherwise. Written halves appear on bus_wdata[15:0] with bus_wdata[31:16] zero.
- R7: An access completes on the first rising edge at which bus_cs is 1 and port_busy is 0. While port_busy is 1, bus_cs, bus_addr, bus_wdata and bus_hsel hold their values.
- R8: A read word is assembled from bus_rdata[15:0] of its two accesses, each half placed by bus_hsel. bus_rdata[31:16] is ignored. rd_valid and rd_data hold until rd_ready.
- R9: In a write command, each data word is taken from wr_data on a wr_valid/wr_ready handshake, one word per two data accesses, in stream order.
- R10: When port_busy stays 1 for tmo_limit consecutive strobed cycles, the command is abandoned: bus_cs drops, err rises, done does not pulse, and cmd_ready returns. err stays 1 until the next command is accepted. A stall one cycle shorter raises nothing, and tmo_limit = 0 disables the timeout.
- R11: done is a single-cycle pulse after the last data word completes. This includes the last rd handshake for reads. With cmd_count = 0, done follows the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_addr | input | 32 | Remote start address |
| cmd_count | input | CW | Number of 32-bit words |
| cmd_write | input | 1 | 1 = host to remote, 0 = remote to host |
| cmd_fixed | input | 1 | Use fixed-location data register |
| cmd_low_first | input | 1 | Low half-word first |
| tmo_limit | input | TW | Busy cycles before abort, 0 = never |
| wr_valid | input | 1 | Outbound word valid |
| wr_ready | output | 1 | Outbound word taken |
| wr_data | input | 32 | Outbound word |
| rd_valid | output | 1 | Inbound word valid |
| rd_ready | input | 1 | Inbound word taken |
| rd_data | output | 32 | Inbound word |
| bus_cs | output | 1 | Port access strobe |
| bus_addr | output | 32 | Host bus address with select and direction |
| bus_wdata | output | 32 | Written half-word on bits 15:0 |
| bus_rdata | input | 32 | Read half-word on bits 15:0 |
| port_busy | input | 1 | Remote not ready, stall access |
| bus_hsel | output | 1 | Half of the word being moved |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Timeout flag |

## Verification
The hardest condition to reach is the timeout boundary. The busy line has to stay high for exactly the limit, or one cycle less, while the sequencer is in the middle of a half-word access. The bench's remote model therefore holds busy for a programmed number of cycles on every access. It runs one command with busy stuck, one with a stall one cycle shorter than the limit, and one with a long stall and the limit set to zero. It also throttles rd_ready so that an assembled read word has to wait at the output while the port sits idle.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    localparam logic [31:0] PORT_BASE = 32'h8000_0000;
    localparam int          DIR_BIT   = 4;
    localparam int          SEL_LSB   = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DINC = 2'd2,
        SEL_DFIX = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WIN,
        ST_DATA,
        ST_ROUT,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic wr;
        logic fixed;
        logic low_first;
    } cmd_mode_t;

    function automatic logic [31:0] port_addr(reg_sel_e sel, logic wr);
        port_addr = PORT_BASE | (32'(wr) << DIR_BIT) | (32'(sel) << SEL_LSB);
    endfunction

endpackage

// File: rtl/hsq_waitctl.sv
module hsq_waitctl #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          busy,
    input  logic [TW-1:0] limit,
    output logic          acc_done,
    output logic          tmo
);
    logic [TW-1:0] stall_q;

    assign acc_done = strobe && !busy;
    assign tmo      = strobe && busy && (limit != '0) && (stall_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= '0;
        end else if (strobe && busy && !tmo) begin
            stall_q <= stall_q + 1'b1;
        end else begin
            stall_q <= '0;
        end
    end

    assert_stall_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe && busy && limit != '0) |-> (stall_q < limit));

endmodule

// File: rtl/hsq_half.sv
module hsq_half #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] word,
    input  logic            ph,
    input  logic            low_first,
    output logic            hsel,
    output logic [HW-1:0]   half
);
    assign hsel = ph ^ ~low_first;
    assign half = hsel ? word[2*HW-1:HW] : word[HW-1:0];
endmodule

// File: rtl/hsq_rdasm.sv
module hsq_rdasm #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic            hsel,
    input  logic [HW-1:0]   din,
    output logic [2*HW-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (cap) begin
            if (hsel) word[2*HW-1:HW] <= din;
            else      word[HW-1:0]    <= din;
        end
    end
endmodule

// File: rtl/hport_seq.sv
module hport_seq
    import hsq_pkg::*;
#(
    parameter int CW = 16,
    parameter int TW = 16,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [31:0]   cmd_addr,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_write,
    input  logic          cmd_fixed,
    input  logic          cmd_low_first,
    input  logic [TW-1:0] tmo_limit,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [31:0]   wr_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [31:0]   rd_data,
    output logic          bus_cs,
    output logic [31:0]   bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic [31:0]   bus_rdata,
    input  logic          port_busy,
    output logic          bus_hsel,
    output logic          done,
    output logic          err
);
    localparam int DW = 2 * HW;

    seq_st_e       st;
    cmd_mode_t     mode;
    logic          ph;
    logic [DW-1:0] word_q;
    logic [31:0]   addr_q;
    logic [CW-1:0] rem_q;
    logic          err_q;
    logic          acc_done;
    logic          tmo;
    logic [HW-1:0] half;
    reg_sel_e      sel;
    logic          dir_wr;

    assign bus_cs = (st == ST_CTRL) || (st == ST_ADDR) || (st == ST_DATA);

    always_comb begin
        sel    = SEL_CTRL;
        dir_wr = 1'b1;
        unique case (st)
            ST_ADDR: sel = SEL_ADDR;
            ST_DATA: begin
                sel    = mode.fixed ? SEL_DFIX : SEL_DINC;
                dir_wr = mode.wr;
            end
            default: sel = SEL_CTRL;
        endcase
    end

    hsq_waitctl #(.TW(TW)) u_wait (
        .clk(clk), .rst(rst), .strobe(bus_cs), .busy(port_busy),
        .limit(tmo_limit), .acc_done(acc_done), .tmo(tmo)
    );

    hsq_half #(.HW(HW)) u_half (
        .word(word_q), .ph(ph), .low_first(mode.low_first),
        .hsel(bus_hsel), .half(half)
    );

    hsq_rdasm #(.HW(HW)) u_rdasm (
        .clk(clk), .rst(rst),
        .cap(acc_done && !tmo && st == ST_DATA && !mode.wr),
        .hsel(bus_hsel), .din(bus_rdata[HW-1:0]), .word(rd_data)
    );

    assign bus_addr  = port_addr(sel, dir_wr);
    assign bus_wdata = (bus_cs && dir_wr) ? 32'(half) : 32'd0;
    assign cmd_ready = (st == ST_IDLE);
    assign wr_ready  = (st == ST_WIN);
    assign rd_valid  = (st == ST_ROUT);
    assign done      = (st == ST_DONE);
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            mode   <= '0;
            ph     <= 1'b0;
            word_q <= '0;
            addr_q <= '0;
            rem_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    mode   <= '{wr: cmd_write, fixed: cmd_fixed, low_first: cmd_low_first};
                    word_q <= DW'(cmd_low_first);
                    addr_q <= cmd_addr;
                    rem_q  <= cmd_count;
                    err_q  <= 1'b0;
                    ph     <= 1'b0;
                    st     <= ST_CTRL;
                end
                ST_CTRL, ST_ADDR, ST_DATA: begin
                    if (tmo) begin
                        err_q <= 1'b1;
                        ph    <= 1'b0;
                        st    <= ST_IDLE;
                    end else if (acc_done) begin
                        ph <= ~ph;
                        if (ph) begin
                            if (st == ST_CTRL) begin
                                word_q <= DW'(addr_q);
                                st     <= ST_ADDR;
                            end else if (st == ST_ADDR) begin
                                if (rem_q == '0)  st <= ST_DONE;
                                else if (mode.wr) st <= ST_WIN;
                                else              st <= ST_DATA;
                            end else if (!mode.wr) begin
                                st <= ST_ROUT;
                            end else begin
                                rem_q <= rem_q - 1'b1;
                                st    <= (rem_q == CW'(1)) ? ST_DONE : ST_WIN;
                            end
                        end
                    end
                end
                ST_WIN: if (wr_valid) begin
                    word_q <= wr_data;
                    st     <= ST_DATA;
                end
                ST_ROUT: if (rd_ready) begin
                    rem_q <= rem_q - 1'b1;
                    st    <= (rem_q == CW'(1)) ? ST_DONE : ST_DATA;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && port_busy && !tmo) |=>
            (bus_cs && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_hsel)));

    assert_half_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_done && !tmo && !ph) |=> (bus_cs && bus_hsel != $past(bus_hsel)));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> (!bus_cs && !done));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tb_hport_seq.sv
module tb_hport_seq;
    localparam int CW = 16;
    localparam int TW = 16;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [31:0]   cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          cmd_write = 1'b0;
    logic          cmd_fixed = 1'b0;
    logic          cmd_low_first = 1'b0;
    logic [TW-1:0] tmo_limit = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [31:0]   wr_data = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b1;
    logic [31:0]   rd_data;
    logic          bus_cs;
    logic [31:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          busy_r = 1'b0;
    logic          bus_hsel;
    logic          done;
    logic          err;

    always #10 clk = ~clk;

    hport_seq #(.CW(CW), .TW(TW), .HW(HW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_write(cmd_write),
        .cmd_fixed(cmd_fixed), .cmd_low_first(cmd_low_first), .tmo_limit(tmo_limit),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .bus_cs(bus_cs), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .port_busy(busy_r), .bus_hsel(bus_hsel),
        .done(done), .err(err)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wpat(int i);
        return {8'hA5, 8'(i), 8'h3C, ~8'(i)};
    endfunction

    // scoreboard queues
    logic [31:0] q_addr[$];
    logic        q_hsel[$];
    logic [15:0] q_wd[$];
    bit          q_cw[$];
    logic [31:0] q_rd[$];

    // remote port model
    int          waits   = 0;
    int          scnt    = 0;
    int          nacc    = 0;
    bit          pending = 0;
    bit          rdy_thr = 0;
    int          cyc     = 0;
    int          src_i   = 0;
    int          gw_i    = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr  = '0;
    logic [15:0] r_lo = '0, r_hi = '0;
    int          r_cnt = 0;

    assign bus_rdata = {16'hFFFF, 16'h3C00 + nacc[15:0]};

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (pending) begin
                nacc++;
                scnt    = 0;
                pending = 0;
            end
            if (bus_cs) begin
                busy_r = (scnt < waits);
                if (busy_r) scnt++;
            end else begin
                busy_r = 1'b0;
                scnt   = 0;
            end
            rd_ready = rdy_thr ? (cyc % 3 != 0) : 1'b1;

            if (prev_stall && !err) begin
                chk(bus_cs, "R7", "strobe held in stall", 32'(bus_cs), 32'd1);
                chk(bus_addr == prev_addr, "R7", "address held in stall", bus_addr, prev_addr);
            end

            if (bus_cs && !busy_r) begin
                pending = 1;
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2", "unexpected access", bus_addr, 32'd0);
                end else begin
                    logic [31:0] ea;
                    logic        eh;
                    logic [15:0] ew;
                    bit          ec;
                    ea = q_addr.pop_front();
                    eh = q_hsel.pop_front();
                    ew = q_wd.pop_front();
                    ec = q_cw.pop_front();
                    chk(bus_addr[31:4] == ea[31:4], "R4", "window/direction", bus_addr, ea);
                    chk(bus_addr[3:2] == ea[3:2], ea[3] ? "R5" : "R2", "register select", bus_addr, ea);
                    chk(bus_hsel == eh, "R6", "half select", 32'(bus_hsel), 32'(eh));
                    if (ec) begin
                        chk(bus_wdata == 32'(ew),
                            (ea[3:2] == 2'd0) ? "R3" : (ea[3:2] == 2'd1) ? "R4" : "R9",
                            "written half", bus_wdata, 32'(ew));
                    end else begin
                        if (bus_hsel) r_hi = bus_rdata[15:0];
                        else          r_lo = bus_rdata[15:0];
                        r_cnt++;
                        if (r_cnt == 2) begin
                            q_rd.push_back({r_hi, r_lo});
                            r_cnt = 0;
                        end
                    end
                end
            end
            prev_stall = bus_cs && busy_r;
            prev_addr  = bus_addr;

            if (rd_valid && rd_ready) begin
                if (q_rd.size() == 0) begin
                    chk(1'b0, "R8", "unexpected read word", rd_data, 32'd0);
                end else begin
                    logic [31:0] er;
                    er = q_rd.pop_front();
                    chk(rd_data == er, "R8", "read word", rd_data, er);
                end
            end

            if (wr_valid && wr_ready) begin
                @(posedge clk);
                #1;
                src_i++;
                wr_data = wpat(src_i);
            end
        end
    end

    task automatic push_word(logic [31:0] a, logic [31:0] w, bit lowf, bit cw);
        for (int ph = 0; ph < 2; ph++) begin
            logic hs;
            hs = lowf ? logic'(ph) : logic'(1 - ph);
            q_addr.push_back(a);
            q_hsel.push_back(hs);
            q_wd.push_back(hs ? w[31:16] : w[15:0]);
            q_cw.push_back(cw);
        end
    endtask

    task automatic run_cmd(logic [31:0] a, int cnt, bit wr, bit fx, bit lowf,
                           int wt, int lim, bit thr, bit exp_tmo, string name);
        int  t;
        bit  got_done;
        bit  got_err;
        waits   = wt;
        rdy_thr = thr;
        if (!exp_tmo) begin
            push_word(32'h8000_0010, {31'd0, lowf}, lowf, 1);
            push_word(32'h8000_0014, a, lowf, 1);
            for (int i = 0; i < cnt; i++) begin
                logic [31:0] da;
                da = 32'h8000_0000 | (wr ? 32'h10 : 32'h0) | (fx ? 32'hC : 32'h8);
                if (wr) begin
                    push_word(da, wpat(gw_i), lowf, 1);
                    gw_i++;
                end else begin
                    push_word(da, 32'd0, lowf, 0);
                end
            end
        end
        @(negedge clk);
        tmo_limit     = TW'(lim);
        cmd_addr      = a;
        cmd_count     = CW'(cnt);
        cmd_write     = wr;
        cmd_fixed     = fx;
        cmd_low_first = lowf;
        cmd_valid     = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        t = 0;
        got_done = 0;
        got_err  = 0;
        while (t < 20000 && !got_done && !got_err) begin
            @(negedge clk);
            t++;
            if (done) got_done = 1;
            if (err)  got_err  = 1;
        end
        if (exp_tmo) begin
            chk(got_err, "R10", {name, ": timeout flag"}, 32'(got_err), 32'd1);
            chk(!got_done, "R10", {name, ": no done on abort"}, 32'(got_done), 32'd0);
            @(negedge clk);
            chk(cmd_ready && !bus_cs, "R10", {name, ": back to idle"}, 32'({cmd_ready, bus_cs}), 32'h2);
            chk(err, "R10", {name, ": flag sticky"}, 32'(err), 32'd1);
        end else begin
            chk(got_done, "R11", {name, ": done pulse"}, 32'(got_done), 32'd1);
            chk(!got_err, "R10", {name, ": no timeout"}, 32'(got_err), 32'd0);
            @(negedge clk);
            chk(!done, "R11", {name, ": done one cycle"}, 32'(done), 32'd0);
            chk(q_addr.size() == 0, "R2", {name, ": all accesses seen"}, 32'(q_addr.size()), 32'd0);
            chk(q_rd.size() == 0, "R8", {name, ": all read words delivered"}, 32'(q_rd.size()), 32'd0);
            chk(src_i == gw_i, "R9", {name, ": stream words consumed"}, 32'(src_i), 32'(gw_i));
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready, "R1", "cmd_ready in reset", 32'(cmd_ready), 32'd1);
        chk(!bus_cs && !done && !err, "R1", "strobe/done/err in reset",
            32'({bus_cs, done, err}), 32'd0);
        chk(!rd_valid && !wr_ready, "R1", "stream handshakes in reset",
            32'({rd_valid, wr_ready}), 32'd0);
        rst = 1'b0;
        wr_data  = wpat(0);
        wr_valid = 1'b1;

        run_cmd(32'h0001_2340, 3, 1, 0, 1, 0, 50, 0, 0, "write auto low-first");
        run_cmd(32'h00AB_CDE8, 2, 1, 1, 0, 2, 50, 0, 0, "write fixed high-first");
        run_cmd(32'h0000_0400, 4, 0, 0, 1, 1, 50, 1, 0, "read auto throttled");
        run_cmd(32'h7777_0000, 1, 0, 1, 0, 3, 50, 0, 0, "read fixed");
        run_cmd(32'h1234_5678, 0, 1, 0, 1, 0, 50, 0, 0, "zero count");
        run_cmd(32'h0000_1000, 2, 0, 0, 1, 1000, 6, 0, 1, "stuck busy");
        run_cmd(32'h0000_2000, 1, 1, 0, 0, 5, 6, 0, 0, "stall below limit");
        chk(!err, "R10", "flag cleared by new command", 32'(err), 32'd0);
        run_cmd(32'h0000_3000, 1, 0, 1, 1, 40, 0, 0, 0, "limit disabled");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule